// File: doc/BRIEF.md
# Operand Forwarding Control Unit

This block steers ALU operands in a five-stage in-order pipeline so that an instruction in the execute stage sees results that older instructions have produced but not yet written back. It takes the two source register numbers of the execute-stage instruction. It also takes the destination number and write enable held in the execute/memory register and in the memory/writeback register. From these it forms one 2-bit select code per operand and drives two 3:1 operand multiplexers.

A second, smaller function covers the decode-stage register read. The register file writes in the first half of a cycle and reads in the second half, so a decode read of the register being written back in the same cycle must return the new value. The block forms that result by comparing each decode read address with the writeback destination. When they match, it substitutes the writeback value for the raw storage output.

The block is purely combinational and has no clock. All interfaces are plain control and data pins with no handshake. Every value is consumed in the same cycle it is presented, so there is no back-pressure.

Top module: `fwd_ctrl_top`

## Requirements
- R1: An operand's select is 2'b10 and its output is the execute/memory ALU result when execute/memory has its write enable high, a nonzero destination, and a destination equal to that operand's source register.
- R2: When R1 does not apply, an operand's select is 2'b01 and its output is the memory/writeback value when memory/writeback has its write enable high, a nonzero destination, and a destination equal to that operand's source register.
- R3: In every other case an operand's select is 2'b00 and its output is the register-file value carried from decode/execute; the code 2'b11 never appears.
- R4: A destination of register 0 never causes forwarding, whatever the enables.
- R5: A stage whose write enable is low never forwards, even on a register match.
- R6: When both stages match the same source, the execute/memory result wins (select 2'b10).
- R7: Operand A and operand B are resolved independently, so each may take a different source in the same cycle.
- R8: A decode read whose address equals a nonzero writeback destination with the write enable high returns the writeback value.
- R9: A decode read at register 0, or while the writeback write enable is low, or at a different address returns the raw storage value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | First source register of the execute-stage instruction |
| ex_src_b | input | 5 | Second source register of the execute-stage instruction |
| ex_rf_a | input | 32 | Register-file value for operand A from decode/execute |
| ex_rf_b | input | 32 | Register-file value for operand B from decode/execute |
| exm_dst | input | 5 | Destination register held in execute/memory |
| exm_wen | input | 1 | Register-write enable held in execute/memory |
| exm_alu | input | 32 | ALU result held in execute/memory |
| mwb_dst | input | 5 | Destination register held in memory/writeback |
| mwb_wen | input | 1 | Register-write enable held in memory/writeback |
| mwb_val | input | 32 | Value being written back (load data or older ALU result) |
| id_rd_a | input | 5 | Decode-stage read address, port A |
| id_rd_b | input | 5 | Decode-stage read address, port B |
| id_raw_a | input | 32 | Raw register-file storage output, port A |
| id_raw_b | input | 32 | Raw register-file storage output, port B |
| sel_a | output | 2 | Select code for operand A |
| sel_b | output | 2 | Select code for operand B |
| opnd_a | output | 32 | Operand A to the ALU |
| opnd_b | output | 32 | Operand B to the ALU |
| id_val_a | output | 32 | Bypassed decode read value, port A |
| id_val_b | output | 32 | Bypassed decode read value, port B |

## Verification
The block holds no state, so any fault shows at the ports in the same cycle as the input pattern that exposes it. A wrong comparison or a wrong priority leaves a stale register-file value or an older writeback value on an operand. The select code then disagrees with the value delivered, and both are compared against the expected source. The stimulus aims at the cases where faults hide: a match on register 0, a match with the enable low, a match in both stages at once, and split matches across the two operands and the two decode ports.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int REG_AW = 5;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SRC_RF  = 2'b00,
    SRC_MWB = 2'b01,
    SRC_EXM = 2'b10
  } opnd_src_e;
endpackage

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] exm_dst,
  input  logic          exm_wen,
  input  logic [AW-1:0] mwb_dst,
  input  logic          mwb_wen,
  output logic [1:0]    sel
);
  logic exm_hit;
  logic mwb_hit;

  // A stage qualifies only when it writes a real (nonzero) register.
  assign exm_hit = exm_wen && (exm_dst != '0) && (exm_dst == src);
  assign mwb_hit = mwb_wen && (mwb_dst != '0) && (mwb_dst == src);

  always_comb begin
    if (exm_hit)      sel = SRC_EXM;
    else if (mwb_hit) sel = SRC_MWB;
    else              sel = SRC_RF;
  end
endmodule

// File: rtl/opnd_mux.sv
module opnd_mux
  import fwd_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [1:0]    sel,
  input  logic [DW-1:0] rf_val,
  input  logic [DW-1:0] exm_val,
  input  logic [DW-1:0] mwb_val,
  output logic [DW-1:0] out
);
  always_comb begin
    unique case (sel)
      SRC_EXM: out = exm_val;
      SRC_MWB: out = mwb_val;
      default: out = rf_val;
    endcase
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass
  import fwd_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] raw_val,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_val,
  output logic [DW-1:0] rd_val
);
  logic hit;
  assign hit    = wr_en && (wr_addr != '0) && (wr_addr == rd_addr);
  assign rd_val = hit ? wr_val : raw_val;
endmodule

// File: rtl/fwd_ctrl_top.sv
module fwd_ctrl_top
  import fwd_pkg::*;
#(
  parameter int AW = REG_AW,
  parameter int DW = DATA_W
) (
  input  logic [AW-1:0] ex_src_a,
  input  logic [AW-1:0] ex_src_b,
  input  logic [DW-1:0] ex_rf_a,
  input  logic [DW-1:0] ex_rf_b,
  input  logic [AW-1:0] exm_dst,
  input  logic          exm_wen,
  input  logic [DW-1:0] exm_alu,
  input  logic [AW-1:0] mwb_dst,
  input  logic          mwb_wen,
  input  logic [DW-1:0] mwb_val,
  input  logic [AW-1:0] id_rd_a,
  input  logic [AW-1:0] id_rd_b,
  input  logic [DW-1:0] id_raw_a,
  input  logic [DW-1:0] id_raw_b,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic [DW-1:0] id_val_a,
  output logic [DW-1:0] id_val_b
);
  localparam int NPORT = 2;

  logic [NPORT-1:0][AW-1:0] src_v;
  logic [NPORT-1:0][DW-1:0] rf_v;
  logic [NPORT-1:0][1:0]    sel_v;
  logic [NPORT-1:0][DW-1:0] op_v;
  logic [NPORT-1:0][AW-1:0] rd_v;
  logic [NPORT-1:0][DW-1:0] raw_v;
  logic [NPORT-1:0][DW-1:0] idv_v;

  assign src_v = {ex_src_b, ex_src_a};
  assign rf_v  = {ex_rf_b, ex_rf_a};
  assign rd_v  = {id_rd_b, id_rd_a};
  assign raw_v = {id_raw_b, id_raw_a};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    fwd_pick #(.AW(AW)) u_pick (
      .src     (src_v[p]),
      .exm_dst (exm_dst),
      .exm_wen (exm_wen),
      .mwb_dst (mwb_dst),
      .mwb_wen (mwb_wen),
      .sel     (sel_v[p])
    );

    opnd_mux #(.DW(DW)) u_mux (
      .sel     (sel_v[p]),
      .rf_val  (rf_v[p]),
      .exm_val (exm_alu),
      .mwb_val (mwb_val),
      .out     (op_v[p])
    );

    rf_bypass #(.AW(AW), .DW(DW)) u_byp (
      .rd_addr (rd_v[p]),
      .raw_val (raw_v[p]),
      .wr_addr (mwb_dst),
      .wr_en   (mwb_wen),
      .wr_val  (mwb_val),
      .rd_val  (idv_v[p])
    );
  end

  assign sel_a    = sel_v[0];
  assign sel_b    = sel_v[1];
  assign opnd_a   = op_v[0];
  assign opnd_b   = op_v[1];
  assign id_val_a = idv_v[0];
  assign id_val_b = idv_v[1];
endmodule

// File: rtl/fwd_ctrl_chk.sv
module fwd_ctrl_chk #(
  parameter int AW = 5,
  parameter int DW = 32
) (
  input logic [AW-1:0] ex_src_a,
  input logic [AW-1:0] ex_src_b,
  input logic [DW-1:0] ex_rf_a,
  input logic [DW-1:0] ex_rf_b,
  input logic [AW-1:0] exm_dst,
  input logic          exm_wen,
  input logic [DW-1:0] exm_alu,
  input logic [AW-1:0] mwb_dst,
  input logic          mwb_wen,
  input logic [DW-1:0] mwb_val,
  input logic [AW-1:0] id_rd_a,
  input logic [AW-1:0] id_rd_b,
  input logic [DW-1:0] id_raw_a,
  input logic [DW-1:0] id_raw_b,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b,
  input logic [DW-1:0] opnd_a,
  input logic [DW-1:0] opnd_b,
  input logic [DW-1:0] id_val_a,
  input logic [DW-1:0] id_val_b
);
  always_comb begin
    // R1
    exm_fwd_a_chk: assert (!(exm_wen && exm_dst != '0 && exm_dst == ex_src_a) || sel_a == 2'b10);
    // R1
    exm_fwd_b_chk: assert (!(exm_wen && exm_dst != '0 && exm_dst == ex_src_b) || sel_b == 2'b10);
    // R3
    no_code3_chk: assert (sel_a != 2'b11 && sel_b != 2'b11);
    // R4
    zero_src_chk: assert ((ex_src_a != '0 || sel_a == 2'b00) && (ex_src_b != '0 || sel_b == 2'b00));
    // R5
    no_wen_chk: assert (exm_wen || mwb_wen || (sel_a == 2'b00 && sel_b == 2'b00));
    // R2
    mwb_route_chk: assert ((sel_a != 2'b01 || opnd_a == mwb_val) && (sel_b != 2'b01 || opnd_b == mwb_val));
    // R1
    exm_route_chk: assert ((sel_a != 2'b10 || opnd_a == exm_alu) && (sel_b != 2'b10 || opnd_b == exm_alu));
    // R3
    rf_route_chk: assert ((sel_a != 2'b00 || opnd_a == ex_rf_a) && (sel_b != 2'b00 || opnd_b == ex_rf_b));
    // R8
    byp_hit_chk: assert (!(mwb_wen && mwb_dst != '0 && mwb_dst == id_rd_a) || id_val_a == mwb_val);
    // R9
    byp_miss_chk: assert (mwb_wen || (id_val_a == id_raw_a && id_val_b == id_raw_b));
  end
endmodule

bind fwd_ctrl_top fwd_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/test_fwd_ctrl_top.sv
module test_fwd_ctrl_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [4:0]  ex_src_a, ex_src_b, exm_dst, mwb_dst, id_rd_a, id_rd_b;
  logic [31:0] ex_rf_a, ex_rf_b, exm_alu, mwb_val, id_raw_a, id_raw_b;
  logic        exm_wen, mwb_wen;
  logic [1:0]  sel_a, sel_b;
  logic [31:0] opnd_a, opnd_b, id_val_a, id_val_b;

  fwd_ctrl_top i_fwd_ctrl_top (.*);

  typedef struct {
    logic [1:0]  sa, sb;
    logic [31:0] oa, ob, ia, ib;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;

  function automatic logic [1:0] want_sel(logic [4:0] s);
    if (exm_wen && exm_dst != 0 && exm_dst == s) return 2'b10;
    if (mwb_wen && mwb_dst != 0 && mwb_dst == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [31:0] want_op(logic [1:0] c, logic [31:0] rf);
    return (c == 2'b10) ? exm_alu : (c == 2'b01) ? mwb_val : rf;
  endfunction

  function automatic logic [31:0] want_id(logic [4:0] a, logic [31:0] raw);
    return (mwb_wen && mwb_dst != 0 && mwb_dst == a) ? mwb_val : raw;
  endfunction

  task automatic push(string tag);
    exp_t e;
    e.sa = want_sel(ex_src_a);
    e.sb = want_sel(ex_src_b);
    e.oa = want_op(e.sa, ex_rf_a);
    e.ob = want_op(e.sb, ex_rf_b);
    e.ia = want_id(id_rd_a, id_raw_a);
    e.ib = want_id(id_rd_b, id_raw_b);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic drive(logic [4:0] sa, logic [4:0] sb, logic [4:0] ed, logic ew,
                       logic [4:0] md, logic mw, logic [4:0] ra, logic [4:0] rb,
                       string tag);
    @(posedge clk);
    #1;
    ex_src_a = sa; ex_src_b = sb;
    exm_dst = ed; exm_wen = ew;
    mwb_dst = md; mwb_wen = mw;
    id_rd_a = ra; id_rd_b = rb;
    push(tag);
  endtask

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      cmp(t, "sel_a", {30'd0, sel_a}, {30'd0, e.sa});
      cmp(t, "sel_b", {30'd0, sel_b}, {30'd0, e.sb});
      cmp(t, "opnd_a", opnd_a, e.oa);
      cmp(t, "opnd_b", opnd_b, e.ob);
      cmp(t, "id_val_a", id_val_a, e.ia);
      cmp(t, "id_val_b", id_val_b, e.ib);
    end
  end

  initial begin
    ex_src_a = 0; ex_src_b = 0; exm_dst = 0; mwb_dst = 0; id_rd_a = 0; id_rd_b = 0;
    exm_wen = 0; mwb_wen = 0;
    ex_rf_a = 32'hA0A0_0001; ex_rf_b = 32'hB0B0_0002;
    exm_alu = 32'hE111_1111; mwb_val = 32'hC222_2222;
    id_raw_a = 32'h1D00_000A; id_raw_b = 32'h1D00_000B;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R3: reset-state pattern, nothing enabled
    drive(0, 0, 0, 0, 0, 0, 0, 0, "R3 idle");
    // R1: newer stage matches operand A
    drive(5'd3, 5'd4, 5'd3, 1, 5'd9, 1, 5'd1, 5'd2, "R1 exm hits A");
    // R2: older stage matches operand B only
    drive(5'd3, 5'd4, 5'd7, 1, 5'd4, 1, 5'd1, 5'd2, "R2 mwb hits B");
    // R6: both stages match both operands
    drive(5'd6, 5'd6, 5'd6, 1, 5'd6, 1, 5'd0, 5'd0, "R6 priority");
    // R4: register 0 destination in both stages
    drive(5'd0, 5'd0, 5'd0, 1, 5'd0, 1, 5'd0, 5'd0, "R4 r0 dst");
    // R5: matches with write enables low
    drive(5'd8, 5'd9, 5'd8, 0, 5'd9, 0, 5'd8, 5'd9, "R5 wen low");
    // R5: newer disabled, older still forwards
    drive(5'd8, 5'd8, 5'd8, 0, 5'd8, 1, 5'd3, 5'd3, "R5 exm off mwb on");
    // R7: A from newer, B from older
    drive(5'd11, 5'd12, 5'd11, 1, 5'd12, 1, 5'd5, 5'd6, "R7 split");
    // R8: decode bypass on port B only
    drive(5'd1, 5'd2, 5'd20, 1, 5'd17, 1, 5'd16, 5'd17, "R8 bypass B");
    // R8: decode bypass on both ports
    drive(5'd1, 5'd2, 5'd20, 1, 5'd21, 1, 5'd21, 5'd21, "R8 bypass both");
    // R9: bypass suppressed for register 0
    drive(5'd1, 5'd2, 5'd20, 1, 5'd0, 1, 5'd0, 5'd0, "R9 r0 read");
    // R9: bypass suppressed with enable low
    drive(5'd1, 5'd2, 5'd20, 1, 5'd21, 0, 5'd21, 5'd21, "R9 wen low");
    // R2: older-stage match on A with newer on other reg
    drive(5'd31, 5'd30, 5'd29, 1, 5'd31, 1, 5'd31, 5'd1, "R2 mwb hits A r31");
    // R1: changing data values must follow
    @(posedge clk); #1;
    exm_alu = 32'h5555_AAAA; ex_rf_b = 32'h0F0F_F0F0;
    ex_src_a = 5'd2; ex_src_b = 5'd9; exm_dst = 5'd2; exm_wen = 1; mwb_wen = 0;
    push("R1 new data");
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule